// File: doc/BRIEF.md
# Banked Working-Register File

This block holds the 32 bytes of working registers of an 8-bit processor core. The storage is split into four banks of eight byte-wide registers, R0 to R7. Three ports reach the same bytes. A register-index port names a register by its number inside the active bank. A direct port uses an 8-bit data address. A unified port uses a 16-bit address that falls inside a small mirror window. A two-bit bank register, loaded by the core, picks which bank the register-index port sees.

All three ports read combinationally from the current contents. Writes land on the rising clock edge. When ports write the same byte in one cycle, a fixed priority decides the result, so every view of a byte always shows one agreed value. The reset input is asserted asynchronously, active low, and is released in step with the clock through an internal synchroniser.

Top module: `banked_regfile`

## Requirements
- R1: While reset is held, and after it is released, all 32 bytes read 0 and the bank register reads 00.
- R2: When bank_ld is high at a clock edge, bank_cur takes bank_din from the next cycle on. Otherwise bank_cur holds. Code 00 selects bank 0, 01 bank 1, 10 bank 2 and 11 bank 3.
- R3: The register-index port reaches byte bank_cur×8 + rx_idx, which is the same byte as direct address {bank_cur, rx_idx}.
- R4: The direct port hits only for da_addr 0x00 to 0x1F and reaches byte da_addr[4:0]. On a miss, da_hit is 0, da_rdata is 0 and a write changes no byte.
- R5: The unified port hits only for ua_addr 0xFF00 to 0xFF1F and reaches byte ua_addr − 0xFF00. On a miss, ua_hit is 0, ua_rdata is 0 and a write changes no byte.
- R6: A byte written through any one port reads back with the new value through the other two ports from the next cycle on.
- R7: A write changes storage only at the clock edge. A read of the same byte in the cycle of the write returns the old value.
- R8: When several ports write one byte in the same cycle, the register-index port wins over the direct port, and the direct port wins over the unified port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_ld | input | 1 | Load the bank register |
| bank_din | input | 2 | New bank code |
| bank_cur | output | 2 | Active bank code |
| rx_idx | input | 3 | Register number within the active bank |
| rx_we | input | 1 | Write enable, register-index port |
| rx_wdata | input | 8 | Write data, register-index port |
| rx_rdata | output | 8 | Read data, register-index port |
| da_addr | input | 8 | Direct data address |
| da_we | input | 1 | Write enable, direct port |
| da_wdata | input | 8 | Write data, direct port |
| da_rdata | output | 8 | Read data, direct port (0 on miss) |
| da_hit | output | 1 | Direct address lies in the register area |
| ua_addr | input | 16 | Unified address |
| ua_we | input | 1 | Write enable, unified port |
| ua_wdata | input | 8 | Write data, unified port |
| ua_rdata | output | 8 | Read data, unified port (0 on miss) |
| ua_hit | output | 1 | Unified address lies in the mirror window |

## Verification
The read data and hit flags are combinational, so they are due in the same cycle the address is applied. They show the contents from before any write in that cycle. A write, and a bank load, become visible one clock edge later. The bench drives inputs at the falling edge and samples the read outputs 1 ns later, before the rising edge that commits the writes. It updates its own byte model only after that sample, so each comparison uses the state the design had when the address was applied. After reset the bench waits out the two-stage release synchroniser before it expects any write to take effect.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  parameter int unsigned DEF_DATA_W   = 8;
  parameter int unsigned DEF_BANKS    = 4;
  parameter int unsigned DEF_REGS     = 8;
  parameter int unsigned DEF_DA_W     = 8;
  parameter int unsigned DEF_UA_W     = 16;
  parameter logic [15:0] DEF_UA_BASE  = 16'hFF00;
  parameter int unsigned DEF_SYNC_LEN = 2;

  // port identifiers in ascending write priority
  typedef enum logic [1:0] {
    SRC_UNI = 2'd0,
    SRC_DIR = 2'd1,
    SRC_IDX = 2'd2
  } wr_src_e;
endpackage

// File: rtl/regfile_rst_sync.sv
module regfile_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/regfile_win_dec.sv
module regfile_win_dec #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned ENT_W  = 5,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ENT_W-1:0]  ent
);
  // window is aligned on its own size, so the upper bits pick it
  localparam logic [ADDR_W-ENT_W-1:0] TAG = BASE[ADDR_W-1:ENT_W];

  always_comb begin
    hit = (addr[ADDR_W-1:ENT_W] == TAG);
    ent = addr[ENT_W-1:0];
  end
endmodule

// File: rtl/regfile_wr_arb.sv
module regfile_wr_arb
  import regfile_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned ENT_W   = 5
) (
  input  logic                           idx_req,
  input  logic [ENT_W-1:0]               idx_ent,
  input  logic [DATA_W-1:0]              idx_dat,
  input  logic                           dir_req,
  input  logic [ENT_W-1:0]               dir_ent,
  input  logic [DATA_W-1:0]              dir_dat,
  input  logic                           uni_req,
  input  logic [ENT_W-1:0]               uni_ent,
  input  logic [DATA_W-1:0]              uni_dat,
  output logic [ENTRIES-1:0]             wen,
  output logic [ENTRIES-1:0][DATA_W-1:0] wdat
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    wr_src_e sel;
    logic    any;

    always_comb begin
      any = 1'b0;
      sel = SRC_UNI;
      if (uni_req && (uni_ent == ENT_W'(i))) begin
        any = 1'b1;
        sel = SRC_UNI;
      end
      if (dir_req && (dir_ent == ENT_W'(i))) begin
        any = 1'b1;
        sel = SRC_DIR;
      end
      if (idx_req && (idx_ent == ENT_W'(i))) begin
        any = 1'b1;
        sel = SRC_IDX;
      end
    end

    always_comb begin
      wen[i] = any;
      unique case (sel)
        SRC_IDX: wdat[i] = idx_dat;
        SRC_DIR: wdat[i] = dir_dat;
        default: wdat[i] = uni_dat;
      endcase
    end
  end
endmodule

// File: rtl/regfile_store.sv
module regfile_store #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ENTRIES = 32
) (
  input  logic                           clk,
  input  logic                           srst_n,
  input  logic [ENTRIES-1:0]             wen,
  input  logic [ENTRIES-1:0][DATA_W-1:0] wdat,
  output logic [ENTRIES-1:0][DATA_W-1:0] mem_q
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_byte
    always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n)     mem_q[i] <= '0;
      else if (wen[i]) mem_q[i] <= wdat[i];
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regfile_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned BANKS    = DEF_BANKS,
  parameter int unsigned REGS     = DEF_REGS,
  parameter int unsigned DA_W     = DEF_DA_W,
  parameter int unsigned UA_W     = DEF_UA_W,
  parameter logic [UA_W-1:0] UA_BASE = UA_W'(DEF_UA_BASE),
  parameter int unsigned SYNC_LEN = DEF_SYNC_LEN,
  localparam int unsigned BANK_W  = $clog2(BANKS),
  localparam int unsigned IDX_W   = $clog2(REGS),
  localparam int unsigned ENT_W   = BANK_W + IDX_W,
  localparam int unsigned ENTRIES = BANKS * REGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_ld,
  input  logic [BANK_W-1:0] bank_din,
  output logic [BANK_W-1:0] bank_cur,
  input  logic [IDX_W-1:0]  rx_idx,
  input  logic              rx_we,
  input  logic [DATA_W-1:0] rx_wdata,
  output logic [DATA_W-1:0] rx_rdata,
  input  logic [DA_W-1:0]   da_addr,
  input  logic              da_we,
  input  logic [DATA_W-1:0] da_wdata,
  output logic [DATA_W-1:0] da_rdata,
  output logic              da_hit,
  input  logic [UA_W-1:0]   ua_addr,
  input  logic              ua_we,
  input  logic [DATA_W-1:0] ua_wdata,
  output logic [DATA_W-1:0] ua_rdata,
  output logic              ua_hit
);
  logic                           srst_n;
  logic [BANK_W-1:0]              bank_q;
  logic [BANK_W-1:0]              bank_d;
  logic [ENT_W-1:0]               rx_ent;
  logic [ENT_W-1:0]               da_ent;
  logic [ENT_W-1:0]               ua_ent;
  logic [ENTRIES-1:0]             wen;
  logic [ENTRIES-1:0][DATA_W-1:0] wdat;
  logic [ENTRIES-1:0][DATA_W-1:0] mem_q;

  regfile_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  // bank register: next state, then storage with its enable
  always_comb begin
    bank_d = bank_q;
    if (bank_ld) bank_d = bank_din;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) bank_q <= '0;
    else         bank_q <= bank_d;
  end

  assign bank_cur = bank_q;
  assign rx_ent   = {bank_q, rx_idx};

  regfile_win_dec #(.ADDR_W(DA_W), .ENT_W(ENT_W), .BASE('0)) u_dec_dir (
    .addr (da_addr),
    .hit  (da_hit),
    .ent  (da_ent)
  );

  regfile_win_dec #(.ADDR_W(UA_W), .ENT_W(ENT_W), .BASE(UA_BASE)) u_dec_uni (
    .addr (ua_addr),
    .hit  (ua_hit),
    .ent  (ua_ent)
  );

  regfile_wr_arb #(.DATA_W(DATA_W), .ENTRIES(ENTRIES), .ENT_W(ENT_W)) u_arb (
    .idx_req (rx_we),
    .idx_ent (rx_ent),
    .idx_dat (rx_wdata),
    .dir_req (da_we && da_hit),
    .dir_ent (da_ent),
    .dir_dat (da_wdata),
    .uni_req (ua_we && ua_hit),
    .uni_ent (ua_ent),
    .uni_dat (ua_wdata),
    .wen     (wen),
    .wdat    (wdat)
  );

  regfile_store #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_store (
    .clk    (clk),
    .srst_n (srst_n),
    .wen    (wen),
    .wdat   (wdat),
    .mem_q  (mem_q)
  );

  // read paths show the state before this cycle's writes
  always_comb begin
    rx_rdata = mem_q[rx_ent];
    da_rdata = da_hit ? mem_q[da_ent] : '0;
    ua_rdata = ua_hit ? mem_q[ua_ent] : '0;
  end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned DA_W    = 8,
  parameter int unsigned UA_W    = 16,
  parameter int unsigned ENT_W   = 5,
  parameter int unsigned ENTRIES = 32
) (
  input logic                           clk,
  input logic                           srst_n,
  input logic                           bank_ld,
  input logic [BANK_W-1:0]              bank_din,
  input logic [BANK_W-1:0]              bank_cur,
  input logic [IDX_W-1:0]               rx_idx,
  input logic                           rx_we,
  input logic [DATA_W-1:0]              rx_wdata,
  input logic [DATA_W-1:0]              rx_rdata,
  input logic [ENT_W-1:0]               rx_ent,
  input logic [DA_W-1:0]                da_addr,
  input logic                           da_we,
  input logic [DATA_W-1:0]              da_wdata,
  input logic [DATA_W-1:0]              da_rdata,
  input logic                           da_hit,
  input logic [UA_W-1:0]                ua_addr,
  input logic                           ua_we,
  input logic [DATA_W-1:0]              ua_wdata,
  input logic [DATA_W-1:0]              ua_rdata,
  input logic                           ua_hit,
  input logic [ENTRIES-1:0][DATA_W-1:0] mem_q
);
  // R2
  bank_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    bank_ld |=> (bank_cur == $past(bank_din)));

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !bank_ld |=> $stable(bank_cur));

  // R8
  idx_write_wins_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rx_we |=> (mem_q[$past(rx_ent)] == $past(rx_wdata)));

  // R8
  dir_over_uni_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (da_we && da_hit && !(rx_we && (rx_ent == da_addr[ENT_W-1:0])))
      |=> (mem_q[$past(da_addr[ENT_W-1:0])] == $past(da_wdata)));

  // R4
  dir_miss_inert_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (da_we && !da_hit && !rx_we && !ua_we) |=> $stable(mem_q));

  // R5
  uni_miss_inert_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ua_we && !ua_hit && !rx_we && !da_we) |=> $stable(mem_q));

  // R6
  dir_uni_agree_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (da_hit && ua_hit && (da_addr[ENT_W-1:0] == ua_addr[ENT_W-1:0]))
      |-> (da_rdata == ua_rdata));

  // R3
  idx_dir_agree_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (da_hit && (da_addr[ENT_W-1:0] == {bank_cur, rx_idx})) |-> (da_rdata == rx_rdata));

  // R7
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!rx_we && !da_we && !ua_we) |=> $stable(mem_q));
endmodule

bind banked_regfile banked_regfile_chk #(
  .DATA_W(DATA_W), .BANK_W(BANK_W), .IDX_W(IDX_W), .DA_W(DA_W),
  .UA_W(UA_W), .ENT_W(ENT_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk(clk), .srst_n(srst_n), .bank_ld(bank_ld), .bank_din(bank_din),
  .bank_cur(bank_cur), .rx_idx(rx_idx), .rx_we(rx_we), .rx_wdata(rx_wdata),
  .rx_rdata(rx_rdata), .rx_ent(rx_ent), .da_addr(da_addr), .da_we(da_we),
  .da_wdata(da_wdata), .da_rdata(da_rdata), .da_hit(da_hit), .ua_addr(ua_addr),
  .ua_we(ua_we), .ua_wdata(ua_wdata), .ua_rdata(ua_rdata), .ua_hit(ua_hit),
  .mem_q(mem_q)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic        clk;
  logic        rst_n;
  logic        bank_ld;
  logic [1:0]  bank_din;
  logic [1:0]  bank_cur;
  logic [2:0]  rx_idx;
  logic        rx_we;
  logic [7:0]  rx_wdata;
  logic [7:0]  rx_rdata;
  logic [7:0]  da_addr;
  logic        da_we;
  logic [7:0]  da_wdata;
  logic [7:0]  da_rdata;
  logic        da_hit;
  logic [15:0] ua_addr;
  logic        ua_we;
  logic [7:0]  ua_wdata;
  logic [7:0]  ua_rdata;
  logic        ua_hit;

  logic [7:0]  mdl [32];
  logic [1:0]  mbank;
  int          n_chk;
  int          n_bad;
  bit          done;

  banked_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bank_ld(bank_ld), .bank_din(bank_din),
    .bank_cur(bank_cur), .rx_idx(rx_idx), .rx_we(rx_we), .rx_wdata(rx_wdata),
    .rx_rdata(rx_rdata), .da_addr(da_addr), .da_we(da_we), .da_wdata(da_wdata),
    .da_rdata(da_rdata), .da_hit(da_hit), .ua_addr(ua_addr), .ua_we(ua_we),
    .ua_wdata(ua_wdata), .ua_rdata(ua_rdata), .ua_hit(ua_hit)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit dir_in(input logic [7:0] a);
    return a < 8'h20;
  endfunction

  function automatic bit uni_in(input logic [15:0] a);
    return (a >= 16'hFF00) && (a <= 16'hFF1F);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // apply inputs just after a falling edge and let the reads settle
  task automatic drive(input bit bl, input logic [1:0] bd,
                       input bit rw, input logic [2:0] ri, input logic [7:0] rd,
                       input bit dw, input logic [7:0] dad, input logic [7:0] dd,
                       input bit uw, input logic [15:0] uad, input logic [7:0] ud);
    bank_ld = bl; bank_din = bd;
    rx_we = rw;   rx_idx = ri;   rx_wdata = rd;
    da_we = dw;   da_addr = dad; da_wdata = dd;
    ua_we = uw;   ua_addr = uad; ua_wdata = ud;
    #1;
  endtask

  // compare all read ports against the model state before the edge
  task automatic check_reads();
    chk("R2", 16'(bank_cur), 16'(mbank));
    chk("R3", 16'(rx_rdata), 16'(mdl[{mbank, rx_idx}]));
    chk("R4", 16'(da_hit), 16'(dir_in(da_addr)));
    chk("R4", 16'(da_rdata), dir_in(da_addr) ? 16'(mdl[da_addr[4:0]]) : 16'h0);
    chk("R5", 16'(ua_hit), 16'(uni_in(ua_addr)));
    chk("R5", 16'(ua_rdata), uni_in(ua_addr) ? 16'(mdl[ua_addr[4:0]]) : 16'h0);
  endtask

  // model update in ascending priority, then clock
  task automatic commit();
    if (ua_we && uni_in(ua_addr)) mdl[ua_addr[4:0]] = ua_wdata;
    if (da_we && dir_in(da_addr)) mdl[da_addr[4:0]] = da_wdata;
    if (rx_we)                    mdl[{mbank, rx_idx}] = rx_wdata;
    if (bank_ld)                  mbank = bank_din;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    drive(0, 2'd0, 0, 3'd0, 8'h0, 0, 8'h0, 8'h0, 0, 16'h0, 8'h0);
  endtask

  task automatic peek_dir(input logic [7:0] a, input logic [7:0] exp, input string req);
    drive(0, 2'd0, 0, 3'd0, 8'h0, 0, a, 8'h0, 0, 16'h0, 8'h0);
    chk(req, 16'(da_rdata), 16'(exp));
    commit();
  endtask

  initial begin
    int seed;
    seed  = $urandom(32'h5A17);
    n_chk = 0; n_bad = 0; done = 0;
    mbank = 2'd0;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    rst_n = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    // R1: storage and bank cleared while reset is held
    #1;
    chk("R1", 16'(bank_cur), 16'h0);
    chk("R1", 16'(da_rdata), 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: every byte reads 0 after release
    for (int i = 0; i < 32; i++) peek_dir(8'(i), 8'h00, "R1");
    chk("R1", 16'(bank_cur), 16'h0);

    // R7: same-cycle read returns the old value
    drive(0, 2'd0, 1, 3'd1, 8'hAA, 0, 8'h01, 8'h0, 0, 16'hFF01, 8'h0);
    chk("R7", 16'(rx_rdata), 16'h00);
    chk("R7", 16'(da_rdata), 16'h00);
    chk("R7", 16'(ua_rdata), 16'h00);
    commit();
    peek_dir(8'h01, 8'hAA, "R7");

    // R8: three ports on byte 5, then two on byte 6, then one on byte 7
    drive(0, 2'd0, 1, 3'd5, 8'h11, 1, 8'h05, 8'h22, 1, 16'hFF05, 8'h33);
    commit();
    peek_dir(8'h05, 8'h11, "R8");
    drive(0, 2'd0, 0, 3'd0, 8'h0, 1, 8'h06, 8'h44, 1, 16'hFF06, 8'h55);
    commit();
    peek_dir(8'h06, 8'h44, "R8");
    drive(0, 2'd0, 0, 3'd0, 8'h0, 0, 8'h00, 8'h00, 1, 16'hFF07, 8'h66);
    commit();
    peek_dir(8'h07, 8'h66, "R8");

    // R6: unified write to byte 0x1A, read as R2 of bank 3
    drive(0, 2'd0, 0, 3'd0, 8'h0, 0, 8'h0, 8'h0, 1, 16'hFF1A, 8'h5C);
    commit();
    drive(1, 2'd3, 0, 3'd0, 8'h0, 0, 8'h0, 8'h0, 0, 16'h0, 8'h0);
    chk("R2", 16'(bank_cur), 16'h0);
    commit();
    chk("R2", 16'(bank_cur), 16'h3);
    drive(0, 2'd0, 0, 3'd2, 8'h0, 0, 8'h1A, 8'h0, 0, 16'hFF1A, 8'h0);
    chk("R6", 16'(rx_rdata), 16'h5C);
    chk("R6", 16'(da_rdata), 16'h5C);
    commit();
    // R6: register-index write in bank 3 seen at unified 0xFF1D
    drive(0, 2'd0, 1, 3'd5, 8'hC3, 0, 8'h0, 8'h0, 0, 16'h0, 8'h0);
    commit();
    drive(0, 2'd0, 0, 3'd0, 8'h0, 0, 8'h0, 8'h0, 0, 16'hFF1D, 8'h0);
    chk("R6", 16'(ua_rdata), 16'hC3);
    commit();

    // R4 / R5: writes outside the windows leave storage alone
    drive(0, 2'd0, 0, 3'd0, 8'h0, 1, 8'h25, 8'hFF, 0, 16'h0, 8'h0);
    chk("R4", 16'(da_hit), 16'h0);
    commit();
    drive(0, 2'd0, 0, 3'd0, 8'h0, 0, 8'h0, 8'h0, 1, 16'hFE05, 8'hEE);
    chk("R5", 16'(ua_hit), 16'h0);
    commit();
    drive(0, 2'd0, 0, 3'd0, 8'h0, 0, 8'h0, 8'h0, 1, 16'hFF20, 8'hDD);
    chk("R5", 16'(ua_rdata), 16'h0);
    commit();
    peek_dir(8'h05, 8'h11, "R4");
    peek_dir(8'h00, 8'h00, "R5");

    // constrained random mix over all ports
    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  dad;
      logic [15:0] uad;
      dad = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 32);
      uad = ($urandom % 8 == 0) ? 16'($urandom) : 16'hFF00 + 16'($urandom % 32);
      drive(($urandom % 6) == 0, 2'($urandom),
            ($urandom % 3) == 0, 3'($urandom), 8'($urandom),
            ($urandom % 3) == 0, dad, 8'($urandom),
            ($urandom % 3) == 0, uad, 8'($urandom));
      check_reads();
      commit();
    end

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule